// File: doc/BRIEF.md
# Statistics Counter Bank with Selectable Clear-on-Read

This block holds a small set of event counters for a network MAC, such as frames received, frames sent and error events. Each counter advances by one on a single-cycle event pulse, but only while the statistics-enable configuration input is high. A shared carry register holds one flag per counter. A flag is set when its counter rolls over from all-ones to zero.

A host reads and writes the counters and the carry register through a plain address, read strobe, write strobe and data port. Read data is registered and comes back one cycle after the strobe. The auto-zero configuration input sets what a read does to its target. With auto-zero high, a read clears the counter or the carry register it returns. With auto-zero low, a read leaves its target alone, and software clears a location by writing zero to it. Both configuration inputs are meant to stay fixed while traffic is counted.

Top module: `stat_bank`

## Requirements
- R1: After synchronous reset, every counter, every carry flag, `rd_valid` and `rd_data` are zero.
- R2: With `cfg_stat_en`=1, an `evt` pulse on bit i adds one to counter i, and the new value is visible to a read issued in the following cycle.
- R3: With `cfg_stat_en`=0, `evt` pulses have no effect on any counter or carry flag.
- R4: A read strobe in cycle t gives `rd_valid`=1 and `rd_data` in cycle t+1. The data is the location's value before any update made in cycle t. `rd_valid` is 0 one cycle after a cycle with no read strobe.
- R5: With `cfg_auto_zero`=1, a read of counter i clears it. If an event for counter i comes in the same cycle, the read returns the pre-event value and the counter becomes 1.
- R6: With `cfg_auto_zero`=0, a read leaves the counter and carry values unchanged. A host write of zero clears the addressed location.
- R7: Counters are `CNT_W` bits wide. An event on counter i while it holds all-ones wraps it to zero and sets carry bit i. The carry register is at address `NUM_CNT`, with bit i belonging to counter i.
- R8: Carry flags are cleared by a read of address `NUM_CNT` when `cfg_auto_zero`=1, and otherwise only by a host write. A wrap in the same cycle as a clearing read leaves its flag set afterwards.
- R9: A host write to address i < `NUM_CNT` loads counter i with `wr_data`. A write to address `NUM_CNT` loads the carry flags from the low bits of `wr_data`. When a write and an event reach the same counter in one cycle, the write wins.
- R10: A read of an address above `NUM_CNT` returns zero. A write to such an address changes no counter and no carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stat_en | input | 1 | Counting enable |
| cfg_auto_zero | input | 1 | 1: reads clear their target; 0: reads leave it |
| evt | input | NUM_CNT | Per-counter event pulses |
| host_addr | input | ADDR_W | Location: counters 0..NUM_CNT-1, carry register at NUM_CNT |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | CNT_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | CNT_W | Registered read data |

## Verification
The collisions that matter are an auto-zero read and an event pulse on the same counter in the same cycle, and a host write and an event on the same counter in the same cycle. A wrap that coincides with a clearing read of the carry register is a third case. The bench sets up each of these directly by driving the read or write strobe together with `evt` on the targeted bit. It then reads the location back, checking that the read returned the pre-event value and the counter holds 1, that the written value won, or that the fresh carry flag survived. A behavioural model steps alongside the design on every clock. It also runs a random phase where such collisions happen by chance under both clear policies.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int unsigned STAT_CNT_W = 32;

    typedef enum logic [1:0] {
        SLOT_COUNTER = 2'd0,
        SLOT_CARRY   = 2'd1,
        SLOT_NONE    = 2'd2
    } slot_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic clr;
    } host_op_t;

    function automatic slot_e slot_of(input int unsigned idx, input int unsigned n);
        if (idx < n)       return SLOT_COUNTER;
        else if (idx == n) return SLOT_CARRY;
        else               return SLOT_NONE;
    endfunction

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         rd_clr,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] count_q;
    logic [W-1:0] base;

    // A clearing read drops the old value; an event in the same cycle then counts from zero.
    always_comb begin
        base = rd_clr ? '0 : count_q;
        wrap = inc && !wr && (&base);
    end

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (wr)   count_q <= wr_val;
        else           count_q <= base + W'(inc);
    end

    assign count = count_q;
endmodule

// File: rtl/stat_carry.sv
module stat_carry #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wrap,
    input  logic         rd_clr,
    input  logic         wr,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] carry
);
    logic [N-1:0] carry_q;

    always_ff @(posedge clk) begin
        if (rst)         carry_q <= '0;
        else if (wr)     carry_q <= wr_val;
        else if (rd_clr) carry_q <= wrap;
        else             carry_q <= carry_q | wrap;
    end

    assign carry = carry_q;
endmodule

// File: rtl/stat_rdport.sv
module stat_rdport
    import stat_pkg::*;
#(
    parameter int unsigned N  = 3,
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd,
    input  logic [AW-1:0]  addr,
    input  logic [N*W-1:0] cnt_flat,
    input  logic [N-1:0]   carry,
    output logic           rd_valid,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] sel;

    always_comb begin
        sel = '0;
        unique case (slot_of(int'(addr), N))
            SLOT_COUNTER: begin
                for (int i = 0; i < N; i++)
                    if (addr == AW'(i)) sel = cnt_flat[i*W +: W];
            end
            SLOT_CARRY:   sel = W'(carry);
            default:      sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd) rd_data <= sel;
        end
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int unsigned NUM_CNT = 3,
    parameter int unsigned CNT_W   = STAT_CNT_W,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_stat_en,
    input  logic               cfg_auto_zero,
    input  logic [NUM_CNT-1:0] evt,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [CNT_W-1:0]   host_wdata,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data
);
    localparam int unsigned FLAT_W = NUM_CNT * CNT_W;

    logic [FLAT_W-1:0]  cnt_flat;
    logic [NUM_CNT-1:0] wrap_v;
    logic [NUM_CNT-1:0] carry_q;
    host_op_t           op;
    slot_e              slot;

    always_comb begin
        slot   = slot_of(int'(host_addr), NUM_CNT);
        op.rd  = host_rd;
        op.wr  = host_wr;
        op.clr = host_rd && cfg_auto_zero;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic hit;
        assign hit = (slot == SLOT_COUNTER) && (host_addr == ADDR_W'(g));
        stat_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (cfg_stat_en && evt[g]),
            .rd_clr (op.clr && hit),
            .wr     (op.wr && hit),
            .wr_val (host_wdata),
            .count  (cnt_flat[g*CNT_W +: CNT_W]),
            .wrap   (wrap_v[g])
        );
    end

    stat_carry #(.N(NUM_CNT)) u_carry (
        .clk    (clk),
        .rst    (rst),
        .wrap   (wrap_v),
        .rd_clr (op.clr && (slot == SLOT_CARRY)),
        .wr     (op.wr && (slot == SLOT_CARRY)),
        .wr_val (host_wdata[NUM_CNT-1:0]),
        .carry  (carry_q)
    );

    stat_rdport #(.N(NUM_CNT), .W(CNT_W), .AW(ADDR_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (op.rd),
        .addr     (host_addr),
        .cnt_flat (cnt_flat),
        .carry    (carry_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
    parameter int unsigned NUM_CNT = 3,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_stat_en,
    input logic                       cfg_auto_zero,
    input logic [ADDR_W-1:0]          host_addr,
    input logic                       host_rd,
    input logic                       host_wr,
    input logic [CNT_W-1:0]           host_wdata,
    input logic                       rd_valid,
    input logic [NUM_CNT*CNT_W-1:0]   cnt_flat,
    input logic [NUM_CNT-1:0]         carry_q
);
    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> rd_valid);
    assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !rd_valid);

    assert_gated_count_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_stat_en && !host_wr && !(host_rd && cfg_auto_zero)) |=> $stable(cnt_flat) && $stable(carry_q));

    assert_read_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !cfg_auto_zero && !cfg_stat_en && !host_wr) |=> $stable(cnt_flat) && $stable(carry_q));

    assert_carry_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (!host_wr && !(host_rd && cfg_auto_zero)) |=> ((carry_q & $past(carry_q)) == $past(carry_q)));

    assert_oor_write_R10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && !cfg_stat_en && (int'(host_addr) > NUM_CNT)) |=> $stable(cnt_flat) && $stable(carry_q));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (host_wr && host_addr == ADDR_W'(i)) |=> (cnt_flat[i*CNT_W +: CNT_W] == $past(host_wdata)));
        assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
            (host_rd && cfg_auto_zero && !host_wr && host_addr == ADDR_W'(i)) |=> (cnt_flat[i*CNT_W +: CNT_W] <= CNT_W'(1)));
    end
endmodule

bind stat_bank stat_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_stat_en   (cfg_stat_en),
    .cfg_auto_zero (cfg_auto_zero),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .rd_valid      (rd_valid),
    .cnt_flat      (cnt_flat),
    .carry_q       (carry_q)
);

// File: tb/tb_stat_bank.sv
module tb_stat_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int W  = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_stat_en, cfg_auto_zero;
    logic [N-1:0]  evt;
    logic [AW-1:0] host_addr;
    logic          host_rd, host_wr;
    logic [W-1:0]  host_wdata;
    logic          rd_valid;
    logic [W-1:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    logic [W-1:0] m_cnt [N];
    logic [N-1:0] m_car;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_bank #(.NUM_CNT(N), .CNT_W(W), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cfg_stat_en(cfg_stat_en), .cfg_auto_zero(cfg_auto_zero),
        .evt(evt), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, step the model at the edge, compare at the next negedge.
    task automatic cyc(input logic [N-1:0] e, input logic rd, input logic wr,
                       input int a, input logic [W-1:0] d, input string tag);
        logic [W-1:0] exp_rd;
        logic [N-1:0] wrapped;
        logic [W-1:0] base;
        evt = e; host_rd = rd; host_wr = wr; host_addr = AW'(a); host_wdata = d;
        @(posedge clk);
        exp_rd = '0;
        if (a < N)       exp_rd = m_cnt[a];
        else if (a == N) exp_rd = W'(m_car);
        wrapped = '0;
        for (int i = 0; i < N; i++) begin
            if (wr && a == i) m_cnt[i] = d;
            else begin
                base = (rd && cfg_auto_zero && a == i) ? '0 : m_cnt[i];
                if (cfg_stat_en && e[i]) begin
                    if (base == '1) wrapped[i] = 1'b1;
                    base = base + 1;
                end
                m_cnt[i] = base;
            end
        end
        if (wr && a == N)                        m_car = d[N-1:0];
        else if (rd && cfg_auto_zero && a == N)  m_car = wrapped;
        else                                     m_car = m_car | wrapped;
        @(negedge clk);
        check("R4", W'(rd_valid), W'(rd));
        if (rd) check(tag, rd_data, exp_rd);
    endtask

    task automatic idle();
        cyc('0, 1'b0, 1'b0, 0, '0, "R4");
    endtask

    task automatic rd(input int a, input string tag);
        cyc('0, 1'b1, 1'b0, a, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_stat_en = 1'b0; cfg_auto_zero = 1'b0;
        evt = '0; host_addr = '0; host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0;
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        m_car = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", W'(rd_valid), '0);
        check("R1", rd_data, '0);
        rst = 1'b0;
        for (int i = 0; i <= N; i++) rd(i, "R1");

        // Keep-after-read policy
        cfg_stat_en = 1'b1;
        cyc(3'b001, 0, 0, 0, '0, "R2");
        cyc(3'b011, 0, 0, 0, '0, "R2");
        cyc(3'b111, 0, 0, 0, '0, "R2");
        rd(0, "R2"); rd(1, "R2"); rd(2, "R2");
        rd(0, "R6");
        cyc('0, 0, 1, 0, '0, "R6");
        rd(0, "R6");
        cyc(3'b010, 0, 1, 1, 32'h0000_0055, "R9");
        rd(1, "R9");
        cyc(3'b100, 1, 0, 2, '0, "R4");
        rd(2, "R4");
        cyc('0, 0, 1, N, 32'h0000_0005, "R9");
        rd(N, "R9");
        cyc('0, 0, 1, N, '0, "R6");
        rd(N, "R6");
        cyc('0, 0, 1, 9, 32'hDEAD_BEEF, "R10");
        rd(9, "R10"); rd(0, "R10"); rd(1, "R10"); rd(2, "R10"); rd(N, "R10");

        // Counting gated off
        cfg_stat_en = 1'b0;
        cyc(3'b111, 0, 0, 0, '0, "R3");
        cyc(3'b111, 0, 0, 0, '0, "R3");
        rd(0, "R3"); rd(1, "R3"); rd(2, "R3"); rd(N, "R3");

        // Clear-on-read policy
        cfg_stat_en = 1'b1; cfg_auto_zero = 1'b1;
        cyc(3'b001, 0, 0, 0, '0, "R2");
        cyc(3'b001, 1, 0, 0, '0, "R5");
        rd(0, "R5");
        rd(0, "R5");
        cyc('0, 0, 1, 1, 32'hFFFF_FFFE, "R9");
        cyc(3'b010, 0, 0, 0, '0, "R7");
        cyc(3'b010, 0, 0, 0, '0, "R7");
        rd(1, "R7");
        rd(N, "R7");
        rd(N, "R8");
        cyc('0, 0, 1, 2, 32'hFFFF_FFFF, "R9");
        cyc(3'b100, 1, 0, N, '0, "R8");
        rd(N, "R8");
        rd(2, "R7");
        cyc('0, 0, 1, 0, 32'hFFFF_FFFF, "R9");
        cyc(3'b001, 1, 0, 0, '0, "R5");
        rd(N, "R5");
        rd(0, "R5");

        // Random traffic under both policies
        for (int k = 0; k < 400; k++) begin
            int a;
            logic r, w;
            if (k % 100 == 0) begin
                cfg_auto_zero = k[7];
                cfg_stat_en   = (k != 300);
            end
            a = int'($urandom_range(0, N + 1));
            r = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 6) == 0);
            cyc(N'($urandom), r, w, a,
                ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : W'($urandom_range(0, 15)), "R2");
        end
        for (int i = 0; i <= N; i++) rd(i, "R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule